// File: doc/BRIEF.md
# Line Fill Unit with Early Restart

This block handles a cache miss when the memory bus is narrower than a cache line, so one line comes back as several beats. On an accepted miss it issues one beat request at a time, starting at the beat that holds the word the processor asked for, and then walks the rest of the line in wrapping order. Each returned beat is written into a line buffer. The processor gets its word as soon as that beat lands, without waiting for the rest of the line.

A per-miss sub-block option fetches only the beat holding the requested word and leaves the other beats of the line empty. Each beat carries its own valid bit. A lookup port compares an address against the line held in the buffer, and it reports a hit only when the beat for that word is valid. A lookup of an unfilled beat in a partial line is therefore seen as a miss.

The miss, memory request and memory response interfaces use valid/ready. A miss is accepted only while `miss_ready` is high, and that happens only between fills. A memory request holds its line address and beat index until `mem_req_ready`. The unit raises `mem_rsp_ready` only while it waits for the one response it has outstanding, and it captures data only on a `mem_rsp_valid` handshake. Either memory side may stall for any number of cycles. The processor response and `fill_done` are single-cycle pulses with no back-pressure.

Top module: `lfu_line_fill`

## Requirements
- R1: After reset, `miss_ready` is 1; `mem_req_valid`, `mem_rsp_ready`, `cpu_rsp_valid`, `fill_done`, `lk_hit` are 0 and `beat_vld` is all zero.
- R2: A miss is taken only on `miss_valid && miss_ready`. `miss_ready` stays 0 from the cycle after acceptance through the `fill_done` cycle. A miss offered meanwhile is ignored, and `mem_req_line_addr` keeps the accepted line address.
- R3: The beat index is the word offset divided by WORDS_PER_BEAT. The k-th request of a fill (k from 0) asks for beat (critical beat + k) mod BEATS. While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_beat` stays unchanged.
- R4: At most one beat is outstanding. `mem_req_valid` and `mem_rsp_ready` are never high together, and a response is captured only on `mem_rsp_valid && mem_rsp_ready`.
- R5: `cpu_rsp_valid` pulses exactly once per fill, in the cycle after the handshake of the critical beat. `cpu_rsp_data` carries word (offset mod WORDS_PER_BEAT) of that beat, and word j sits at bits [j*WORD_W +: WORD_W].
- R6: With sub-block mode off, all BEATS beats are requested. Beat b is then readable on `line_data` at bits [b*BEAT_W +: BEAT_W].
- R7: `sub_blk_en` is sampled at acceptance. When it is 1, only the critical beat is requested and only its valid bit is set.
- R8: `beat_vld[b]` becomes 1 in the cycle after beat b's handshake. All bits read 0 in the cycle after a new miss is accepted.
- R9: `fill_done` is a one-cycle pulse in the cycle after the last beat's handshake. `miss_ready` returns to 1 in the following cycle.
- R10: `lk_hit` is 1 only when `lk_line_addr` equals the line of the latest accepted miss and the beat of `lk_word` is valid. On a hit, `lk_data` is that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_blk_en | input | 1 | Fetch only the critical beat for the miss being accepted |
| miss_valid | input | 1 | Miss request offered |
| miss_ready | output | 1 | Unit idle, miss can be taken |
| miss_line_addr | input | ADDR_W | Line address of the miss |
| miss_word | input | WOFF_W | Word offset within the line |
| mem_req_valid | output | 1 | Beat read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line_addr | output | ADDR_W | Line address of the request |
| mem_req_beat | output | BIDX_W | Beat index requested |
| mem_rsp_valid | input | 1 | Beat data valid |
| mem_rsp_ready | output | 1 | Unit waiting for a beat |
| mem_rsp_data | input | BEAT_W | Beat data |
| cpu_rsp_valid | output | 1 | Early response pulse |
| cpu_rsp_data | output | WORD_W | Requested word |
| beat_vld | output | BEATS | Per-beat valid bits of the buffered line |
| line_data | output | LINE_W | Buffered line, beat b at [b*BEAT_W +: BEAT_W] |
| fill_done | output | 1 | Fill finished pulse |
| lk_line_addr | input | ADDR_W | Lookup line address |
| lk_word | input | WOFF_W | Lookup word offset |
| lk_hit | output | 1 | Lookup hit on a valid beat |
| lk_data | output | WORD_W | Lookup word |

## Verification
The bench builds the unit with 8-bit words, two words per beat, four beats per line and a 6-bit line address. This makes every word offset, every wrap start and every partial-line valid pattern small enough to sweep in full. Each offset runs under both fetch modes, on several lines, with request and response stalls of zero to two cycles and with a competing miss held active during the fill. After each fill, the bench does a lookup at every word of the line and at a non-matching line. That confirms which beats count as valid and that unfilled beats miss.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } lfu_state_e;
endpackage

// File: rtl/lfu_beat_seq.sv
// Beat order generator: starts at the critical beat, wraps modulo BEATS,
// and flags the final beat of the fill (one beat in sub-block mode).
module lfu_beat_seq #(
  parameter int BEATS = 4,
  localparam int BIDX_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              sub_in,
  input  logic [BIDX_W-1:0] crit_in,
  input  logic              step,
  output logic [BIDX_W-1:0] beat_idx,
  output logic              last_beat
);
  localparam logic [BIDX_W-1:0] TOP_IDX = BIDX_W'(BEATS - 1);

  logic [BIDX_W-1:0] ptr_q;
  logic [BIDX_W-1:0] cnt_q;
  logic              sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
      sub_q <= 1'b0;
    end else if (load) begin
      ptr_q <= crit_in;
      cnt_q <= '0;
      sub_q <= sub_in;
    end else if (step) begin
      ptr_q <= (ptr_q == TOP_IDX) ? '0 : ptr_q + 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign beat_idx  = ptr_q;
  assign last_beat = sub_q || (cnt_q == TOP_IDX);
endmodule

// File: rtl/lfu_line_store.sv
// Line buffer: one register and one valid flag per beat, plus a word read port.
module lfu_line_store #(
  parameter int WORD_W = 32,
  parameter int WPB    = 2,
  parameter int BEATS  = 4,
  localparam int BEAT_W = WORD_W * WPB,
  localparam int LINE_W = BEAT_W * BEATS,
  localparam int BIDX_W = $clog2(BEATS),
  localparam int SUB_W  = $clog2(WPB),
  localparam int WOFF_W = BIDX_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [BIDX_W-1:0] wr_idx,
  input  logic [BEAT_W-1:0] wr_data,
  input  logic [WOFF_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_ok,
  output logic [BEATS-1:0]  vld,
  output logic [LINE_W-1:0] line_flat
);
  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic [BEAT_W-1:0] data_q;
    logic              ok_q;
    logic              hit_w;

    assign hit_w = wr_en && (wr_idx == BIDX_W'(b));

    always_ff @(posedge clk) begin
      if (hit_w) data_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ok_q <= 1'b0;
      else if (clr)   ok_q <= 1'b0;
      else if (hit_w) ok_q <= 1'b1;
    end

    assign vld[b] = ok_q;
    assign line_flat[b*BEAT_W +: BEAT_W] = data_q;
  end

  logic [BIDX_W-1:0] rd_beat;
  logic [SUB_W-1:0]  rd_sub;
  logic [BEAT_W-1:0] rd_row;

  assign rd_beat = rd_word[WOFF_W-1:SUB_W];
  assign rd_sub  = rd_word[SUB_W-1:0];
  assign rd_row  = line_flat[int'(rd_beat)*BEAT_W +: BEAT_W];
  assign rd_data = rd_row[int'(rd_sub)*WORD_W +: WORD_W];
  assign rd_ok   = vld[rd_beat];
endmodule

// File: rtl/lfu_line_fill.sv
// Miss fill controller with critical-word-first order and early response.
module lfu_line_fill
  import lfu_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int WORD_W = 32,
  parameter int WPB    = 2,
  parameter int BEATS  = 4,
  localparam int BEAT_W = WORD_W * WPB,
  localparam int LINE_W = BEAT_W * BEATS,
  localparam int BIDX_W = $clog2(BEATS),
  localparam int SUB_W  = $clog2(WPB),
  localparam int WOFF_W = BIDX_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_blk_en,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_line_addr,
  input  logic [WOFF_W-1:0] miss_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_line_addr,
  output logic [BIDX_W-1:0] mem_req_beat,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [BEAT_W-1:0] mem_rsp_data,
  output logic              cpu_rsp_valid,
  output logic [WORD_W-1:0] cpu_rsp_data,
  output logic [BEATS-1:0]  beat_vld,
  output logic [LINE_W-1:0] line_data,
  output logic              fill_done,
  input  logic [ADDR_W-1:0] lk_line_addr,
  input  logic [WOFF_W-1:0] lk_word,
  output logic              lk_hit,
  output logic [WORD_W-1:0] lk_data
);
  lfu_state_e st_q, st_d;

  logic              take_miss;
  logic              rsp_hs;
  logic              crit_hs;
  logic [ADDR_W-1:0] addr_q;
  logic [WOFF_W-1:0] woff_q;
  logic              live_q;
  logic              rsp_v_q;
  logic [WORD_W-1:0] rsp_d_q;
  logic [BIDX_W-1:0] cur_beat;
  logic              last_beat;
  logic              rd_ok;

  assign take_miss = (st_q == ST_IDLE) && miss_valid;
  assign rsp_hs    = (st_q == ST_FILL) && mem_rsp_valid;
  assign crit_hs   = rsp_hs && (cur_beat == woff_q[WOFF_W-1:SUB_W]);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (miss_valid)    st_d = ST_REQ;
      ST_REQ:  if (mem_req_ready) st_d = ST_FILL;
      ST_FILL: if (mem_rsp_valid) st_d = last_beat ? ST_DONE : ST_REQ;
      ST_DONE:                    st_d = ST_IDLE;
      default:                    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      woff_q  <= '0;
      live_q  <= 1'b0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= crit_hs;
      if (take_miss) begin
        addr_q <= miss_line_addr;
        woff_q <= miss_word;
        live_q <= 1'b1;
      end
      if (crit_hs) begin
        rsp_d_q <= mem_rsp_data[int'(woff_q[SUB_W-1:0])*WORD_W +: WORD_W];
      end
    end
  end

  lfu_beat_seq #(.BEATS(BEATS)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_miss),
    .sub_in    (sub_blk_en),
    .crit_in   (miss_word[WOFF_W-1:SUB_W]),
    .step      (rsp_hs),
    .beat_idx  (cur_beat),
    .last_beat (last_beat)
  );

  lfu_line_store #(.WORD_W(WORD_W), .WPB(WPB), .BEATS(BEATS)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (take_miss),
    .wr_en     (rsp_hs),
    .wr_idx    (cur_beat),
    .wr_data   (mem_rsp_data),
    .rd_word   (lk_word),
    .rd_data   (lk_data),
    .rd_ok     (rd_ok),
    .vld       (beat_vld),
    .line_flat (line_data)
  );

  assign miss_ready        = (st_q == ST_IDLE);
  assign mem_req_valid     = (st_q == ST_REQ);
  assign mem_req_line_addr = addr_q;
  assign mem_req_beat      = cur_beat;
  assign mem_rsp_ready     = (st_q == ST_FILL);
  assign fill_done         = (st_q == ST_DONE);
  assign cpu_rsp_valid     = rsp_v_q;
  assign cpu_rsp_data      = rsp_d_q;
  assign lk_hit            = live_q && (lk_line_addr == addr_q) && rd_ok;
endmodule

// File: rtl/lfu_line_fill_chk.sv
module lfu_line_fill_chk #(
  parameter int BEATS = 4,
  localparam int BIDX_W = $clog2(BEATS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [BIDX_W-1:0] mem_req_beat,
  input logic              mem_rsp_valid,
  input logic              mem_rsp_ready,
  input logic              cpu_rsp_valid,
  input logic              fill_done,
  input logic [BEATS-1:0]  beat_vld
);
  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  assert_busy_in_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |-> !miss_ready);

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_beat)));

  assert_one_side_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  assert_rsp_follows_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(mem_rsp_valid && mem_rsp_ready));

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);

  assert_vld_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> ($countones(beat_vld) == 0));

  assert_vld_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(miss_valid && miss_ready) |=> ((beat_vld & $past(beat_vld)) == $past(beat_vld)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (!fill_done && miss_ready));
endmodule

bind lfu_line_fill lfu_line_fill_chk #(.BEATS(BEATS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_ready    (miss_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_beat  (mem_req_beat),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .fill_done     (fill_done),
  .beat_vld      (beat_vld)
);

// File: tb/lfu_line_fill_tb.sv
`timescale 1ns/1ps
module lfu_line_fill_tb_top;
  localparam int AW = 6;
  localparam int WW = 8;
  localparam int WP = 2;
  localparam int NB = 4;
  localparam int BW = WW * WP;
  localparam int LW = BW * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sub_blk_en = 1'b0;
  logic          miss_valid = 1'b0;
  logic          miss_ready;
  logic [AW-1:0] miss_line_addr = '0;
  logic [2:0]    miss_word = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_line_addr;
  logic [1:0]    mem_req_beat;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ready;
  logic [BW-1:0] mem_rsp_data = '0;
  logic          cpu_rsp_valid;
  logic [WW-1:0] cpu_rsp_data;
  logic [NB-1:0] beat_vld;
  logic [LW-1:0] line_data;
  logic          fill_done;
  logic [AW-1:0] lk_line_addr = '0;
  logic [2:0]    lk_word = '0;
  logic          lk_hit;
  logic [WW-1:0] lk_data;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  lfu_line_fill #(.ADDR_W(AW), .WORD_W(WW), .WPB(WP), .BEATS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .sub_blk_en(sub_blk_en),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_line_addr(miss_line_addr), .miss_word(miss_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line_addr(mem_req_line_addr), .mem_req_beat(mem_req_beat),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_data(cpu_rsp_data), .beat_vld(beat_vld), .line_data(line_data),
    .fill_done(fill_done), .lk_line_addr(lk_line_addr), .lk_word(lk_word),
    .lk_hit(lk_hit), .lk_data(lk_data)
  );

  function automatic logic [WW-1:0] word_of(int a, int w);
    return WW'(a * 29 + w * 11 + 3);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_fill(int a, int w, bit sub, int rq_st, int rs_st, bit spam);
    int crit = w / WP;
    int exp_n = sub ? 1 : NB;
    int mask = sub ? (1 << crit) : ((1 << NB) - 1);
    int k = 0;
    int wc = 0;
    int rsps = 0;
    int cyc = 0;
    int cur = 0;
    bit done = 1'b0;
    bit drove_crit = 1'b0;
    bit exp_rsp;

    check(miss_ready == 1'b1, "R2 ready before miss", miss_ready, 1);
    miss_valid = 1'b1;
    miss_line_addr = AW'(a);
    miss_word = 3'(w);
    sub_blk_en = sub;
    @(posedge clk); @(negedge clk);
    check(beat_vld == '0, "R8 valid cleared at start", beat_vld, 0);
    check(miss_ready == 1'b0, "R2 busy after accept", miss_ready, 0);
    if (spam) begin
      miss_valid = 1'b1;
      miss_line_addr = AW'(a ^ 6'h2a);
      miss_word = 3'(w ^ 5);
    end else begin
      miss_valid = 1'b0;
    end
    sub_blk_en = ~sub;

    while (!done && cyc < 100) begin
      exp_rsp = drove_crit;
      drove_crit = 1'b0;
      if (cpu_rsp_valid || exp_rsp) begin
        check(cpu_rsp_valid == exp_rsp, "R5 response timing", cpu_rsp_valid, exp_rsp);
        if (cpu_rsp_valid) begin
          rsps++;
          check(cpu_rsp_data == word_of(a, w), "R5 response word", cpu_rsp_data, word_of(a, w));
        end
      end
      check(!(mem_req_valid && mem_rsp_ready), "R4 single direction", mem_rsp_ready, 0);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (fill_done) begin
        done = 1'b1;
        check(k == exp_n, "R6 R7 beats fetched", k, exp_n);
        check(int'(beat_vld) == mask, "R7 R8 valid mask", beat_vld, mask);
        check(miss_ready == 1'b0, "R9 busy in done", miss_ready, 0);
      end else begin
        check(miss_ready == 1'b0, "R2 busy during fill", miss_ready, 0);
        if (mem_req_valid) begin
          check(int'(mem_req_beat) == (crit + k) % NB, "R3 beat order",
                mem_req_beat, (crit + k) % NB);
          check(int'(mem_req_line_addr) == a, "R2 line addr held", mem_req_line_addr, a);
          if (wc >= rq_st) begin
            mem_req_ready = 1'b1;
            cur = int'(mem_req_beat);
            wc = 0;
          end else begin
            wc++;
          end
        end else if (mem_rsp_ready) begin
          if (wc >= rs_st) begin
            mem_rsp_valid = 1'b1;
            for (int j = 0; j < WP; j++)
              mem_rsp_data[j*WW +: WW] = word_of(a, cur * WP + j);
            if (cur == crit) drove_crit = 1'b1;
            k++;
            wc = 0;
          end else begin
            mem_rsp_data = '1;
            wc++;
          end
        end
      end
      @(posedge clk); @(negedge clk);
      cyc++;
    end
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    miss_valid = 1'b0;
    check(done, "R9 fill completes", done, 1);
    check(miss_ready == 1'b1, "R9 ready after done", miss_ready, 1);
    check(fill_done == 1'b0, "R9 done is one pulse", fill_done, 0);
    check(rsps == 1, "R5 single response", rsps, 1);

    for (int b = 0; b < NB; b++) begin
      if (mask[b]) begin
        for (int j = 0; j < WP; j++)
          check(line_data[b*BW + j*WW +: WW] == word_of(a, b * WP + j), "R6 line data",
                line_data[b*BW + j*WW +: WW], word_of(a, b * WP + j));
      end
    end
    for (int ww = 0; ww < NB * WP; ww++) begin
      lk_line_addr = AW'(a);
      lk_word = 3'(ww);
      #1;
      check(lk_hit == mask[ww / WP], "R10 lookup hit", lk_hit, mask[ww / WP]);
      if (lk_hit) check(lk_data == word_of(a, ww), "R10 lookup data", lk_data, word_of(a, ww));
      lk_line_addr = AW'(a ^ 5);
      #1;
      check(lk_hit == 1'b0, "R10 other line misses", lk_hit, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(miss_ready == 1'b1, "R1 ready", miss_ready, 1);
    check(mem_req_valid == 1'b0, "R1 req idle", mem_req_valid, 0);
    check(mem_rsp_ready == 1'b0, "R1 rsp idle", mem_rsp_ready, 0);
    check(cpu_rsp_valid == 1'b0, "R1 cpu idle", cpu_rsp_valid, 0);
    check(fill_done == 1'b0, "R1 done low", fill_done, 0);
    check(beat_vld == '0, "R1 valid clear", beat_vld, 0);
    #1;
    check(lk_hit == 1'b0, "R1 lookup miss", lk_hit, 0);

    for (int li = 0; li < 3; li++) begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < NB * WP; w++) begin
          do_fill(7 + li * 19, w, s[0], w % 3, (w + s + li) % 3, bit'((w + li) & 1));
          repeat (li) @(negedge clk);
        end
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule